// File: doc/BRIEF.md
# Triggered Readout Pipeline with Bunch Counter

The block records the data presented on every bunch crossing into a fixed-size history ring, and tags each crossing with the value of a local bunch-crossing counter. A trigger accept arrives a fixed number of crossings after the crossing that caused it. That number is the configured latency. When an accept arrives, the block takes the data and counter value of that earlier crossing from the ring and queues them as one event in a small output FIFO.

The counter restarts from a programmable offset on a reset strobe, which keeps it in step with the machine and with other modules. The FIFO hands events downstream over a valid/ready pair. When downstream stalls and the FIFO nears full, a busy veto with hysteresis tells the trigger source to hold off. Accepts that still find the FIFO full are dropped, and a saturating counter records each one.

Top module: `trig_readout_pipe`

## Requirements
- R1: An accept sampled at clock edge t queues the `din` value sampled at edge t-L, where L is `cfg_latency` (1..255). The value 0 is treated as 1.
- R2: The `ev_bcid` of a queued event is the bunch counter value at the edge on which its crossing's `din` was sampled.
- R3: The bunch counter is 0 after reset. It advances by one per clock and goes from 3563 back to 0.
- R4: A `bcr` sampled at an edge loads `cfg_bc_offset` (valid range 0..3563) into the counter, so that crossing carries that value.
- R5: Events leave in arrival order through a 16-entry FIFO. `ev_valid` is high when the FIFO is not empty. The head holds stable while `ev_valid` is high and `ev_ready` is low, and it is consumed on an edge where both are high.
- R6: An accept that finds 16 entries stored, judged before any same-edge pop, is not queued and adds one to `ovf_count`. The count saturates at all ones.
- R7: `busy` rises on the edge after the free space is 4 or less. It falls on the edge after the free space is 8 or more, and otherwise holds its value.
- R8: After reset, `ev_valid`, `busy` and `ovf_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DATA_W | Per-crossing data |
| l1a | input | 1 | Trigger accept strobe |
| bcr | input | 1 | Bunch counter reset strobe |
| cfg_latency | input | LAT_W | Accept latency in crossings |
| cfg_bc_offset | input | BC_W | Value loaded into the counter on `bcr` |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Downstream accepts the event |
| ev_data | output | DATA_W | Event crossing data |
| ev_bcid | output | BC_W | Event bunch-crossing number |
| busy | output | 1 | Veto toward the trigger source |
| ovf_count | output | OVF_W | Dropped accepts |

## Verification
The bench tries latencies of 1, 255 and 0. A pointer off by one would return the neighbouring crossing, and a ring one entry too short would return a stale crossing at 255. It loads an offset close to 3563 so that accepted crossings straddle the wrap; a counter that wraps at the wrong value or loads one cycle late gives wrong `ev_bcid` values. It fills the FIFO with `ev_ready` low and fires accepts on the same edge as a pop from a full FIFO. A design that judged fullness after the pop would queue an extra event, leave the overflow count low, or hold `busy` at the wrong moment.

// File: rtl/trig_readout_pipe.sv
module trig_readout_pipe #(
  parameter int DATA_W        = 16,
  parameter int BC_W          = 12,
  parameter int BC_LAST       = 3563,
  parameter int LAT_W         = 8,
  parameter int FIFO_AW       = 4,
  parameter int BUSY_ON_FREE  = 4,
  parameter int BUSY_OFF_FREE = 8,
  parameter int OVF_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              l1a,
  input  logic              bcr,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic [BC_W-1:0]   cfg_bc_offset,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [DATA_W-1:0] ev_data,
  output logic [BC_W-1:0]   ev_bcid,
  output logic              busy,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int RING   = 1 << LAT_W;
  localparam int FIFO_D = 1 << FIFO_AW;
  localparam int EV_W   = BC_W + DATA_W;

  logic [EV_W-1:0]    ring [RING];
  logic [EV_W-1:0]    fifo [FIFO_D];
  logic [LAT_W-1:0]   wp, lat_eff;
  logic [BC_W-1:0]    bc;
  logic [EV_W-1:0]    sel;
  logic [FIFO_AW-1:0] f_wr, f_rd;
  logic [FIFO_AW:0]   f_cnt, f_free;
  logic               full, push, pop;

  assign lat_eff = (cfg_latency == '0) ? LAT_W'(1) : cfg_latency;
  assign sel     = ring[wp - lat_eff];
  assign full    = (f_cnt == (FIFO_AW+1)'(FIFO_D));
  assign push    = l1a && !full;
  assign pop     = ev_valid && ev_ready;
  assign f_free  = (FIFO_AW+1)'(FIFO_D) - f_cnt;
  assign ev_valid = (f_cnt != '0);
  assign {ev_bcid, ev_data} = fifo[f_rd];

  always_ff @(posedge clk) ring[wp] <= {bc, din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wp <= '0;
    else        wp <= wp + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    bc <= '0;
    else if (bcr)                  bc <= cfg_bc_offset;
    else if (bc == BC_W'(BC_LAST)) bc <= '0;
    else                           bc <= bc + 1'b1;

  always_ff @(posedge clk) if (push) fifo[f_wr] <= sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_wr  <= '0;
      f_rd  <= '0;
      f_cnt <= '0;
    end else begin
      if (push) f_wr <= f_wr + 1'b1;
      if (pop)  f_rd <= f_rd + 1'b1;
      case ({push, pop})
        2'b10:   f_cnt <= f_cnt + 1'b1;
        2'b01:   f_cnt <= f_cnt - 1'b1;
        default: f_cnt <= f_cnt;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 ovf_count <= '0;
    else if (l1a && full && ovf_count != '1)    ovf_count <= ovf_count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                            busy <= 1'b0;
    else if (f_free <= (FIFO_AW+1)'(BUSY_ON_FREE))         busy <= 1'b1;
    else if (f_free >= (FIFO_AW+1)'(BUSY_OFF_FREE))        busy <= 1'b0;

  p_bc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcr && bc == BC_W'(BC_LAST)) |=> bc == '0);
  p_bc_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bcr |=> bc == $past(cfg_bc_offset));
  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> ev_valid && $stable(ev_data) && $stable(ev_bcid));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && full && ovf_count != '1) |=> ovf_count == $past(ovf_count) + 1'b1);
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && full && !ev_ready) |=> full);
  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (f_free <= (FIFO_AW+1)'(BUSY_ON_FREE)) |=> busy);
  p_busy_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (f_free >= (FIFO_AW+1)'(BUSY_OFF_FREE)) |=> !busy);
endmodule

// File: tb/trig_readout_pipe_tb.sv
module trig_readout_pipe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] din = '0;
  logic l1a = 1'b0, bcr = 1'b0, ev_ready = 1'b1;
  logic [7:0] cfg_latency = 8'd10;
  logic [11:0] cfg_bc_offset = '0;
  logic ev_valid, busy;
  logic [15:0] ev_data, ovf_count;
  logic [11:0] ev_bcid;

  int checks = 0, fails = 0;
  bit live = 0;

  logic [27:0] hist[$];
  logic [27:0] q[$];
  int bc_m = 0, ovf_m = 0;
  bit busy_m = 0;

  trig_readout_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .l1a(l1a), .bcr(bcr),
    .cfg_latency(cfg_latency), .cfg_bc_offset(cfg_bc_offset),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
    .ev_bcid(ev_bcid), .busy(busy), .ovf_count(ovf_count));

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); q.delete();
      bc_m = 0; ovf_m = 0; busy_m = 0;
    end else begin
      int lat, free;
      bit pop;
      logic [27:0] sel;
      hist.push_back({12'(bc_m), din});
      if (hist.size() > 300) void'(hist.pop_front());
      lat  = (cfg_latency == 0) ? 1 : int'(cfg_latency);
      free = 16 - q.size();
      if (free <= 4) busy_m = 1; else if (free >= 8) busy_m = 0;
      pop = (q.size() != 0) && ev_ready;
      sel = hist[hist.size() - 1 - lat];
      if (l1a) begin
        if (q.size() == 16) begin
          if (ovf_m != 16'hffff) ovf_m++;
        end
      end
      if (pop) void'(q.pop_front());
      if (l1a && (q.size() + (pop ? 1 : 0)) < 16) q.push_back(sel);
      if (bcr) bc_m = int'(cfg_bc_offset);
      else if (bc_m == 3563) bc_m = 0;
      else bc_m++;
    end
  end

  always @(negedge clk) if (live) begin
    chk("R5 ev_valid", ev_valid, q.size() != 0);
    if (q.size() != 0) begin
      chk("R1 ev_data", ev_data, q[0][15:0]);
      chk("R2 R3 R4 ev_bcid", ev_bcid, q[0][27:16]);
    end
    chk("R7 busy", busy, busy_m);
    chk("R6 ovf_count", ovf_count, ovf_m);
  end

  task automatic cyc(bit a, bit r);
    @(negedge clk);
    l1a = a; bcr = r; din = 16'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ev_valid reset", ev_valid, 0);
    chk("R8 busy reset", busy, 0);
    chk("R8 ovf reset", ovf_count, 0);
    live = 1;
    repeat (300) cyc(0, 0);
    cfg_bc_offset = 12'd3500;
    cyc(0, 1);
    for (int i = 0; i < 240; i++) begin
      case ((i / 7) % 4)
        0: cfg_latency = 8'd1;
        1: cfg_latency = 8'd255;
        2: cfg_latency = 8'd0;
        default: cfg_latency = 8'd37;
      endcase
      cyc(i % 7 == 0, 0);
    end
    cfg_bc_offset = 12'd5; cfg_latency = 8'd3;
    cyc(0, 1);
    repeat (4) cyc(1, 0);
    repeat (10) cyc(0, 0);
    ev_ready = 1'b0;
    repeat (25) cyc(1, 0);
    repeat (3) cyc(0, 0);
    ev_ready = 1'b1;
    cyc(1, 0);
    repeat (30) begin cyc(1, 0); cyc(0, 0); cyc(0, 0); end
    for (int i = 0; i < 3000; i++) begin
      ev_ready = ($urandom % 4) == 0;
      cfg_latency = 8'($urandom);
      cyc(($urandom % 3) == 0, ($urandom % 500) == 0);
    end
    ev_ready = 1'b1;
    repeat (40) cyc(0, 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule